// File: doc/BRIEF.md
# I2C Bus Master with Software-Paced Clock Stretch

This block is a single-master I2C controller that is paced byte by byte from a simple pulse-and-level control interface. Firmware pulses a start request, then writes the address byte (seven address bits above a read/write bit) and any data bytes. Each write starts the shifting of that byte. Between bytes the controller holds SCL low and waits. It reports the slave's acknowledge, exposes the last shifted byte, and shows whether it owns the bus.

Both bus lines are open-drain. The block drives them only through output enables, where an enable of 1 pulls the line low, and it reads the real line levels back. The SCL rate comes from a half-period count in system clocks. Each byte has a wait point, chosen by a level input, either just after the 8th SCL falling edge or just after the 9th. At that point the block raises a one-cycle interrupt and parks SCL low until firmware releases it or writes the next byte. With the early wait point, firmware can decide the acknowledge level of a received byte before the 9th clock is issued.

Top module: `i2c_wait_master`

## Requirements
- R1: While reset is applied, and after it, both output enables are 0 and `irq`, `bus_active` and `ack_seen` are 0.
- R2: `start_req` while both bus lines are high pulls SDA low with SCL released. SCL is first pulled low exactly `half_period` clocks after SDA fell.
- R3: `bus_active` rises only after the block has seen SDA fall while SCL is high, so it is still 0 in the cycle in which SDA first reads low. It falls only after SDA is seen rising while SCL is high.
- R4: Bytes go out most significant bit first. For the address byte, bit 0 is the direction bit, where 1 means read.
- R5: For a transmitted byte, `ack_seen` is sampled from SDA at the rising edge of the 9th clock. It is 1 when the line is low and 0 when it is high, and it changes only while SCL is released.
- R6: `irq` is a one-cycle pulse at the byte's wait point. With `wait_on_ninth`=1 that point follows the 9th SCL falling edge; with 0 it follows the 8th. It fires whether or not the slave acknowledged.
- R7: Once at a stall, SCL stays low until `release_req`, `wr_byte` or `stop_req` arrives.
- R8: `half_period` must be at least 2. Each SCL high phase lasts `half_period` clocks, and so does each low phase between two data bits of one byte.
- R9: `stop_req` at a stall drives SDA low, releases SCL, then releases SDA while SCL is high. After that `bus_active` clears and both enables are 0.
- R10: After an address byte with bit 0 = 1, the following bytes are received. The block leaves SDA released for the 8 data bits, and `rd_data` holds the byte most significant bit first.
- R11: On the 9th clock of a received byte, SDA is pulled low exactly when `ack_enable` is 1.
- R12: With `wait_on_ninth`=0, the 9th clock is followed directly by the next byte in two cases: the byte was received and acknowledged, or a `wr_byte` arrived during the 8th-clock stall. Otherwise SCL is parked low with no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | DIV_W | SCL half period in system clocks (at least 2) |
| wait_on_ninth | input | 1 | 1: stall after 9th clock; 0: stall after 8th clock |
| ack_enable | input | 1 | Acknowledge level driven on the 9th clock of received bytes |
| start_req | input | 1 | Pulse: generate a start condition from idle |
| stop_req | input | 1 | Pulse at a stall: generate a stop condition |
| release_req | input | 1 | Pulse at a stall: resume clocking |
| wr_byte | input | 1 | Pulse: load `wr_data` and resume |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last byte shifted through the register |
| ack_seen | output | 1 | Acknowledge sampled on the last transmitted byte |
| bus_active | output | 1 | Block owns the bus (own start seen, no stop yet) |
| irq | output | 1 | One-cycle pulse at the wait point |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench pairs the block with a behavioural slave on a wired-AND bus. It sweeps three divider values, both wait points and the write, mismatched-address and read flows, with bytes derived from the loop indices. It targets the start-hold length: a controller that drops SCL too early or too late shows a different low-SDA/high-SCL span. It also checks the slave's bit position at each interrupt, so a block that stalls at the wrong clock is caught. In the early-wait mode it confirms that a byte written during the stall is sent with no further stall, and that an unacknowledged read parks silently. A design that mixed these up would either hang, which the interrupt timeout catches, or raise an interrupt while parked.

// File: rtl/i2c_wm_pkg.sv
`timescale 1ns/1ps
package i2c_wm_pkg;
    localparam int BYTE_W = 8;
    localparam int BCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_STALL, ST_LOW, ST_HIGH, ST_STOP_A, ST_STOP_B, ST_STOP_C
    } wm_state_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } wm_drive_t;

    // Line enables per phase; data_low is the bit-level SDA pull for LOW/HIGH.
    function automatic wm_drive_t phase_drive(wm_state_t st, logic data_low);
        wm_drive_t d;
        d.scl_low = 1'b0;
        d.sda_low = 1'b0;
        case (st)
            ST_START:            d.sda_low = 1'b1;
            ST_STALL:            d.scl_low = 1'b1;
            ST_LOW:  begin       d.scl_low = 1'b1; d.sda_low = data_low; end
            ST_HIGH:             d.sda_low = data_low;
            ST_STOP_A: begin     d.scl_low = 1'b1; d.sda_low = 1'b1; end
            ST_STOP_B:           d.sda_low = 1'b1;
            default: ;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/i2c_wm_halftimer.sv
`timescale 1ns/1ps
module i2c_wm_halftimer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             freeze,
    input  logic [DIV_W-1:0] half,
    output logic             expire,
    output logic             fresh
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (restart)
            cnt <= half - DIV_W'(1);
        else if (!freeze && cnt != '0)
            cnt <= cnt - DIV_W'(1);
    end

    assign expire = (cnt == '0) && !freeze;
    assign fresh  = (cnt == half - DIV_W'(1));
endmodule

// File: rtl/i2c_wm_busmon.sv
`timescale 1ns/1ps
module i2c_wm_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic active
);
    logic scl_q, sda_q;
    logic saw_start, saw_stop;

    assign saw_start = scl_in && scl_q && sda_q && !sda_in;
    assign saw_stop  = scl_in && scl_q && !sda_q && sda_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            active <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (saw_start)
                active <= 1'b1;
            else if (saw_stop)
                active <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_wm_seq.sv
`timescale 1ns/1ps
module i2c_wm_seq
    import i2c_wm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wait_on_ninth,
    input  logic              ack_enable,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              release_req,
    input  logic              wr_byte,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              expire,
    input  logic              fresh,
    output logic              restart,
    output logic              freeze,
    output wm_drive_t         drive,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ack_seen,
    output logic              irq
);
    localparam logic [BCNT_W-1:0] LAST_DATA = BCNT_W'(BYTE_W - 1);
    localparam logic [BCNT_W-1:0] ACK_SLOT  = BCNT_W'(BYTE_W);

    wm_state_t         state, state_n;
    logic [BCNT_W-1:0] bcnt;
    logic [BYTE_W-1:0] sreg;
    logic              samp, addr_phase, dir_rx, preload, irq_set;
    logic              rx_byte, data_low, resume, high_done;

    assign rx_byte   = dir_rx && !addr_phase;
    assign data_low  = (bcnt == ACK_SLOT) ? (rx_byte && ack_enable)
                                          : (!rx_byte && !sreg[BYTE_W-1]);
    assign resume    = !stop_req && (release_req || wr_byte);
    assign high_done = (state == ST_HIGH) && expire;

    always_comb begin
        state_n = state;
        irq_set = 1'b0;
        case (state)
            ST_IDLE:   if (start_req && scl_in && sda_in) state_n = ST_START;
            ST_START:  if (expire) state_n = ST_STALL;
            ST_STALL:  if (stop_req) state_n = ST_STOP_A;
                       else if (resume) state_n = ST_LOW;
            ST_LOW:    if (expire) state_n = ST_HIGH;
            ST_HIGH: if (expire) begin
                if (bcnt == LAST_DATA) begin
                    state_n = wait_on_ninth ? ST_LOW : ST_STALL;
                    irq_set = !wait_on_ninth;
                end else if (bcnt == ACK_SLOT) begin
                    if (wait_on_ninth) begin
                        state_n = ST_STALL;
                        irq_set = 1'b1;
                    end else if (preload || (rx_byte && ack_enable))
                        state_n = ST_LOW;
                    else
                        state_n = ST_STALL;
                end else
                    state_n = ST_LOW;
            end
            ST_STOP_A: if (expire) state_n = ST_STOP_B;
            ST_STOP_B: if (expire) state_n = ST_STOP_C;
            ST_STOP_C: if (expire) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    assign restart = (state_n != state);
    assign freeze  = (state == ST_HIGH || state == ST_STOP_B) && !scl_in;
    assign drive   = phase_drive(state, data_low);
    assign rd_data = sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bcnt       <= '0;
            sreg       <= '0;
            samp       <= 1'b0;
            addr_phase <= 1'b0;
            dir_rx     <= 1'b0;
            preload    <= 1'b0;
            ack_seen   <= 1'b0;
            irq        <= 1'b0;
        end else begin
            state <= state_n;
            irq   <= irq_set;
            if (state == ST_START && expire) begin
                bcnt       <= '0;
                addr_phase <= 1'b1;
                dir_rx     <= 1'b0;
                preload    <= 1'b0;
            end
            if (state == ST_STALL && resume && wr_byte) begin
                sreg    <= wr_data;
                preload <= (bcnt == ACK_SLOT);
            end
            if (state == ST_HIGH && fresh && scl_in) begin
                samp <= sda_in;
                if (bcnt == ACK_SLOT && !rx_byte)
                    ack_seen <= !sda_in;
            end
            if (high_done) begin
                if (bcnt == ACK_SLOT) begin
                    bcnt       <= '0;
                    addr_phase <= 1'b0;
                    preload    <= 1'b0;
                end else begin
                    sreg <= {sreg[BYTE_W-2:0], samp};
                    bcnt <= bcnt + BCNT_W'(1);
                    if (bcnt == LAST_DATA && addr_phase)
                        dir_rx <= samp;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_wait_master.sv
`timescale 1ns/1ps
module i2c_wait_master
    import i2c_wm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  half_period,
    input  logic              wait_on_ninth,
    input  logic              ack_enable,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              release_req,
    input  logic              wr_byte,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ack_seen,
    output logic              bus_active,
    output logic              irq,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    logic      restart, freeze, expire, fresh;
    wm_drive_t drive;

    i2c_wm_halftimer #(.DIV_W(DIV_W)) timer_i (
        .clk(clk), .rst(rst), .restart(restart), .freeze(freeze),
        .half(half_period), .expire(expire), .fresh(fresh)
    );

    i2c_wm_busmon mon_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .active(bus_active)
    );

    i2c_wm_seq seq_i (
        .clk(clk), .rst(rst), .wait_on_ninth(wait_on_ninth), .ack_enable(ack_enable),
        .start_req(start_req), .stop_req(stop_req), .release_req(release_req),
        .wr_byte(wr_byte), .wr_data(wr_data), .scl_in(scl_in), .sda_in(sda_in),
        .expire(expire), .fresh(fresh), .restart(restart), .freeze(freeze),
        .drive(drive), .rd_data(rd_data), .ack_seen(ack_seen), .irq(irq)
    );

    assign scl_oe = drive.scl_low;
    assign sda_oe = drive.sda_low;
endmodule

// File: rtl/i2c_wm_chk.sv
`timescale 1ns/1ps
module i2c_wm_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_in,
    input logic scl_oe,
    input logic bus_active,
    input logic irq,
    input logic ack_seen
);
    // R3: ownership begins only on an observed start condition
    a_r3_active_follows_start: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_active) |-> $past(scl_in && !sda_in));

    // R9: ownership ends only on an observed stop condition
    a_r9_active_ends_on_stop: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_active) |-> $past(scl_in && sda_in));

    // R6: the wait-point interrupt lasts one cycle
    a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7: the interrupt is raised with SCL held low
    a_r7_irq_in_stall: assert property (@(posedge clk) disable iff (rst)
        irq |-> scl_oe);

    // R5: acknowledge status moves only during an SCL high phase
    a_r5_ack_while_high: assert property (@(posedge clk) disable iff (rst)
        $changed(ack_seen) |-> $past(!scl_oe));
endmodule

bind i2c_wait_master i2c_wm_chk chk_i (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
    .bus_active(bus_active), .irq(irq), .ack_seen(ack_seen)
);

// File: tb/i2c_wait_master_tb_top.sv
`timescale 1ns/1ps
module i2c_wait_master_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] half_period = 8'd2;
    logic       wait_on_ninth = 1'b1, ack_enable = 1'b0;
    logic       start_req = 1'b0, stop_req = 1'b0, release_req = 1'b0, wr_byte = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ack_seen, bus_active, irq, scl_oe, sda_oe, scl_in, sda_in;
    logic       slv_oe = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_in = ~scl_oe;
    assign sda_in = ~(sda_oe | slv_oe);

    i2c_wait_master dut_i (
        .clk(clk), .rst(rst), .half_period(half_period), .wait_on_ninth(wait_on_ninth),
        .ack_enable(ack_enable), .start_req(start_req), .stop_req(stop_req),
        .release_req(release_req), .wr_byte(wr_byte), .wr_data(wr_data),
        .rd_data(rd_data), .ack_seen(ack_seen), .bus_active(bus_active), .irq(irq),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int n_chk = 0, n_bad = 0;
    int cur_h = 2;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural slave and bus monitor ----------------
    localparam logic [6:0] SLV = 7'h2B;
    logic [7:0] rd_pat [0:3];
    logic [7:0] cap    [0:3];
    bit         mack   [0:3];
    logic [7:0] shreg = 8'h00;
    int  bitn = 0, byten = 0, starts = 0, stops = 0, hi_len = 0, lo_len = 0;
    bit  match = 0, rd = 0, rose = 0, done = 0;
    logic scl_p = 1'b1, sda_p = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            slv_oe = 1'b0; scl_p = 1'b1; sda_p = 1'b1; rose = 0;
        end else begin
            if (scl_in && scl_p && sda_p && !sda_in) begin
                starts++; bitn = 0; byten = 0; match = 0; rd = 0; rose = 0; done = 0;
                slv_oe = 1'b0;
            end
            if (scl_in && scl_p && !sda_p && sda_in) begin
                stops++; match = 0; rose = 0; slv_oe = 1'b0;
            end
            if (scl_in && !scl_p) begin
                if (rose && bitn >= 1 && bitn <= 7)
                    chk("R8 low phase length", lo_len, cur_h);
                rose = 1; hi_len = 1;
                if (bitn < 8) begin
                    shreg = {shreg[6:0], sda_in};
                    if (bitn == 7) begin
                        if (byten == 0) begin
                            match = (shreg[7:1] == SLV); rd = shreg[0];
                        end else if (byten < 4) cap[byten] = shreg;
                    end
                end else if (byten >= 1 && byten < 4) begin
                    mack[byten] = !sda_in;
                    if (rd && sda_in) done = 1;
                end
            end else if (!scl_in && scl_p) begin
                if (rose) begin
                    chk("R8 high phase length", hi_len, cur_h);
                    if (bitn == 8) begin bitn = 0; byten++; end
                    else bitn++;
                end
                lo_len = 1;
                if (!match || done) slv_oe = 1'b0;
                else if (bitn == 8) slv_oe = (byten == 0) || !rd;
                else slv_oe = rd && byten >= 1 && byten < 4 && !rd_pat[byten][7-bitn];
            end else if (scl_in) hi_len++;
            else lo_len++;
            scl_p = scl_in; sda_p = sda_in;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_start();
        int hold;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        chk("R2 SDA low, SCL high after start", {sda_in, scl_in}, 2'b01);
        chk("R3 active not yet set when SDA falls", bus_active, 0);
        hold = 1;
        while (scl_in && hold < 1000) begin @(negedge clk); if (scl_in) hold++; end
        chk("R2 start hold length", hold, cur_h);
        chk("R3 active after own start", bus_active, 1);
    endtask

    task automatic do_write(input logic [7:0] b);
        @(negedge clk) begin wr_byte = 1'b1; wr_data = b; end
        @(negedge clk) wr_byte = 1'b0;
    endtask

    task automatic do_release();
        @(negedge clk) release_req = 1'b1;
        @(negedge clk) release_req = 1'b0;
    endtask

    task automatic wait_irq(input int exp_bitn, input string tag);
        int t = 0, hi = 0;
        do begin @(negedge clk); t++; end while (!irq && t < 4000);
        chk({"R6 irq reached ", tag}, irq, 1);
        @(negedge clk);
        chk({"R6 slave bit position at irq ", tag}, bitn, exp_bitn);
        repeat (12) begin @(negedge clk); if (scl_in) hi++; end
        chk({"R7 SCL held low at stall ", tag}, hi, 0);
    endtask

    task automatic park_check(input string tag);
        int irqs = 0;
        repeat (2 * cur_h + 8) begin @(negedge clk); if (irq) irqs++; end
        chk({"R12 no irq when parking ", tag}, irqs, 0);
        chk({"R12 SCL parked low ", tag}, scl_in, 0);
    endtask

    task automatic do_stop();
        int s0 = stops, t = 0;
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
        while (stops == s0 && t < 500) begin @(negedge clk); t++; end
        chk("R9 stop condition seen", stops - s0, 1);
        repeat (3) @(negedge clk);
        chk("R9 active cleared after stop", bus_active, 0);
        chk("R9 lines released after stop", {scl_oe, sda_oe}, 0);
    endtask

    task automatic run_write(input bit w9, input logic [7:0] d1, input logic [7:0] d2);
        do_start();
        do_write({SLV, 1'b0});
        if (w9) begin
            wait_irq(0, "addr w9");
            chk("R5 address ACK", ack_seen, 1);
            do_write(d1); wait_irq(0, "d1 w9");
            chk("R5 data ACK", ack_seen, 1);
            do_write(d2); wait_irq(0, "d2 w9");
        end else begin
            wait_irq(8, "addr w8");
            do_release(); park_check("addr tx");
            chk("R5 address ACK", ack_seen, 1);
            do_write(d1); wait_irq(8, "d1 w8");
            do_write(d2); wait_irq(8, "R12 preloaded d2 w8");
            do_release(); park_check("d2 tx");
        end
        chk("R5 last data ACK", ack_seen, 1);
        chk("R4 address matched at slave", match, 1);
        chk("R4 first data byte on bus", cap[1], d1);
        chk("R4 second data byte on bus", cap[2], d2);
        do_stop();
    endtask

    task automatic run_nack(input bit w9);
        do_start();
        do_write({SLV ^ 7'h11, 1'b0});
        if (w9) wait_irq(0, "nack w9");
        else begin
            wait_irq(8, "nack w8");
            do_release(); park_check("nack");
        end
        chk("R5 NACK on unknown address", ack_seen, 0);
        do_stop();
    endtask

    task automatic run_read(input bit w9, input logic [7:0] p1, input logic [7:0] p2);
        rd_pat[1] = p1; rd_pat[2] = p2; rd_pat[3] = 8'h00;
        do_start();
        do_write({SLV, 1'b1});
        ack_enable = 1'b1;
        if (w9) begin
            wait_irq(0, "raddr w9");
            chk("R5 read address ACK", ack_seen, 1);
            do_release(); wait_irq(0, "r1 w9");
            chk("R10 first received byte", rd_data, p1);
            chk("R11 master ACK on first byte", mack[1], 1);
            ack_enable = 1'b0;
            do_release(); wait_irq(0, "r2 w9");
            chk("R10 second received byte", rd_data, p2);
            chk("R11 master NACK on last byte", mack[2], 0);
        end else begin
            wait_irq(8, "raddr w8");
            do_release(); park_check("raddr");
            chk("R5 read address ACK", ack_seen, 1);
            do_release(); wait_irq(8, "r1 w8");
            chk("R10 first received byte", rd_data, p1);
            do_release(); wait_irq(8, "R12 auto-continue r2 w8");
            chk("R11 master ACK on first byte", mack[1], 1);
            chk("R10 second received byte", rd_data, p2);
            ack_enable = 1'b0;
            do_release(); park_check("r2 nack");
            chk("R11 master NACK on last byte", mack[2], 0);
        end
        do_stop();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        chk("R1 enables during reset", {scl_oe, sda_oe}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 enables after reset", {scl_oe, sda_oe}, 0);
        chk("R1 flags after reset", {irq, bus_active, ack_seen}, 0);
        for (int h = 2; h <= 5; h += (h == 3) ? 2 : 1) begin
            cur_h = h;
            half_period = 8'(h);
            for (int w = 0; w < 2; w++) begin
                wait_on_ninth = w[0];
                run_write(w[0], 8'hA5 ^ 8'(h * 17 + w), 8'h3C + 8'(h * 5 + w * 64));
                run_nack(w[0]);
                run_read(w[0], 8'h96 ^ 8'(h * 9 + w * 3), 8'h41 + 8'(h * 31 + w));
            end
        end
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule